// File: doc/BRIEF.md
# Indexed Master Data Buffer

This block is an 8 KB word-addressed data store placed next to a bus master engine. For outbound (write) transfers the engine pulls data beats out of the store. For inbound (read) transfers the engine pushes beats into it. Each transfer starts from an index carried by a command descriptor. The block turns that index into a byte address, steps the address by one beat per accepted transfer, and wraps at the end of the store.

A host register port sees the store as 32-bit words in a window based at 0xC000. Software uses it to preload outbound data and to collect inbound data. The master data width is a parameter (32, 64, 128, 256 or 512). It sets how many 32-bit words move in one beat. It also sets how an inbound index is read: as an 8-byte entry number at 64 bits or less, and as a byte offset aligned to the beat size above 64 bits.

Top module: `idx_buffer_ram`

## Requirements
- R1: After reset every word of the store reads as zero, and `e_ready`, `e_err` and `h_rvalid` are low.
- R2: A host write to address 0xC000+4k stores `h_wdata` in word k. A host read of 0xC000+4k returns word k on `h_rdata` with `h_rvalid` high one cycle after acceptance, and `h_rdata` holds otherwise.
- R3: For an outbound transfer (`e_capture`=0) the first beat starts at byte 8*index. Lane i (`e_rdata[32i+31:32i]`) is the word at that start plus 4i.
- R4: For an inbound transfer with a data width of 64 bits or less, the first beat is stored starting at byte 8*index, lane 0 at the lowest address.
- R5: For an inbound transfer with a data width above 64 bits, the index is a byte offset. The first beat is stored at that offset with its low log2(width/8) bits cleared, lane 0 at the lowest address.
- R6: Each accepted beat advances the address by width/8 bytes.
- R7: A wide inbound index with any nonzero low bits sets `e_err`. An aligned start, or any outbound start, clears it. `e_err` only changes on a start.
- R8: Addresses wrap modulo 8 KB, so a beat that runs past 0xDFFF continues at 0xC000.
- R9: Words not covered by an inbound beat keep their prior contents.
- R10: An engine beat transfer has priority. In a cycle with `e_valid` and `e_ready` high, `h_ready` is low and the host access is not performed until a later cycle.
- R11: `e_ready` rises the cycle after `e_start` and falls after the accepted beat carrying `e_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 16 | Host byte address, window at 0xC000 |
| h_wdata | input | 32 | Host write data |
| h_ready | output | 1 | Host access accepted this cycle |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 32 | Host read data |
| e_start | input | 1 | Start a transfer with `e_index` |
| e_capture | input | 1 | 1 = inbound (store beats), 0 = outbound (supply beats) |
| e_index | input | log2(BUF_BYTES) | Descriptor index |
| e_valid | input | 1 | Engine offers a beat |
| e_ready | output | 1 | Transfer open, beat accepted when `e_valid` |
| e_last | input | 1 | Final beat of the transfer |
| e_wdata | input | DATA_W | Inbound beat data |
| e_rdata | output | DATA_W | Outbound beat data at current address |
| e_err | output | 1 | Misaligned wide inbound index |

## Verification
On every cycle the assertions check the handshake rules: host stall under an engine transfer, one-cycle read response with held data, the opening and closing of a transfer, and that the error flag moves only on a start. Address arithmetic can only be shown by the directed scenarios, which read the store back through the host port. This covers entry versus aligned-offset indexing, lane order, beat stepping, rounding of a misaligned index, wrap at the top of the store and preservation of neighbouring words. A second instance at 64-bit width covers the narrow inbound mapping.

// File: rtl/idx_buffer_ram.sv
`timescale 1ns/1ps
module idx_buffer_ram #(
  parameter int DATA_W    = 128,
  parameter int BUF_BYTES = 8192
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         h_req,
  input  logic                         h_we,
  input  logic [15:0]                  h_addr,
  input  logic [31:0]                  h_wdata,
  output logic                         h_ready,
  output logic                         h_rvalid,
  output logic [31:0]                  h_rdata,
  input  logic                         e_start,
  input  logic                         e_capture,
  input  logic [$clog2(BUF_BYTES)-1:0] e_index,
  input  logic                         e_valid,
  output logic                         e_ready,
  input  logic                         e_last,
  input  logic [DATA_W-1:0]            e_wdata,
  output logic [DATA_W-1:0]            e_rdata,
  output logic                         e_err
);
  localparam int AW     = $clog2(BUF_BYTES);
  localparam int WAW    = AW - 2;
  localparam int WORDS  = BUF_BYTES / 4;
  localparam int LANES  = DATA_W / 32;
  localparam int BEAT_B = DATA_W / 8;
  localparam bit WIDE   = DATA_W > 64;

  logic [31:0]    mem [WORDS];
  logic           active, cap;
  logic [AW-1:0]  ptr;
  logic [WAW-1:0] lane_w [LANES];

  logic [AW-1:0] entry_base, aligned_base, start_base, low_mask;
  logic          use_wide, misal, xfer, h_rd_acc, h_wr_acc;
  logic [WAW-1:0] h_word;

  assign low_mask     = AW'(BEAT_B - 1);
  assign entry_base   = e_index << 3;
  assign aligned_base = e_index & ~low_mask;
  assign use_wide     = e_capture && WIDE;
  assign start_base   = use_wide ? aligned_base : entry_base;
  assign misal        = use_wide && ((e_index & low_mask) != '0);

  assign xfer     = active && e_valid;
  assign e_ready  = active;
  assign h_ready  = !xfer;
  assign h_word   = h_addr[AW-1:2];
  assign h_rd_acc = h_req && !h_we && h_ready;
  assign h_wr_acc = h_req && h_we && h_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_w[i] = ptr[AW-1:2] + WAW'(i);
    assign e_rdata[32*i +: 32] = mem[lane_w[i]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WORDS; k++) mem[k] <= '0;
    end else if (xfer && cap) begin
      for (int i = 0; i < LANES; i++) mem[lane_w[i]] <= e_wdata[32*i +: 32];
    end else if (h_wr_acc) begin
      mem[h_word] <= h_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cap      <= 1'b0;
      ptr      <= '0;
      e_err    <= 1'b0;
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      if (e_start) begin
        active <= 1'b1;
        cap    <= e_capture;
        ptr    <= start_base;
        e_err  <= misal;
      end else if (xfer) begin
        ptr <= ptr + AW'(BEAT_B);
        if (e_last) active <= 1'b0;
      end
      h_rvalid <= h_rd_acc;
      if (h_rd_acc) h_rdata <= mem[h_word];
    end
  end
endmodule

module idx_buffer_ram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_req,
  input logic        h_we,
  input logic        h_ready,
  input logic        h_rvalid,
  input logic [31:0] h_rdata,
  input logic        e_start,
  input logic        e_valid,
  input logic        e_ready,
  input logic        e_last,
  input logic        e_err
);
  assert_host_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (e_valid && e_ready) |-> !h_ready);
  assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we && h_ready) |=> h_rvalid);
  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_req && !h_we && h_ready) |=> !h_rvalid);
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_req && !h_we && h_ready) |=> $stable(h_rdata));
  assert_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    e_start |=> e_ready);
  assert_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (e_valid && e_ready && e_last && !e_start) |=> !e_ready);
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !e_start |=> $stable(e_err));
endmodule

bind idx_buffer_ram idx_buffer_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_ready(h_ready),
  .h_rvalid(h_rvalid), .h_rdata(h_rdata), .e_start(e_start), .e_valid(e_valid),
  .e_ready(e_ready), .e_last(e_last), .e_err(e_err)
);

// File: tb/test_idx_buffer_ram.sv
`timescale 1ns/1ps
module test_idx_buffer_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        h_req = 0, h_we = 0;
  logic [15:0] h_addr = 0;
  logic [31:0] h_wdata = 0;
  logic        h_ready, h_rvalid, n_hready, n_hrvalid;
  logic [31:0] h_rdata, n_hrdata;
  logic        e_start = 0, e_capture = 0, e_valid = 0, e_last = 0;
  logic        n_start = 0, n_valid = 0;
  logic [12:0] e_index = 0;
  logic [127:0] e_wdata = 0;
  logic [127:0] e_rdata;
  logic [63:0]  n_rdata;
  logic        e_ready, e_err, n_ready, n_err;

  int checks = 0, errors = 0;

  idx_buffer_ram #(.DATA_W(128)) i_idx_buffer_ram (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_ready(h_ready), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .e_start(e_start), .e_capture(e_capture), .e_index(e_index), .e_valid(e_valid),
    .e_ready(e_ready), .e_last(e_last), .e_wdata(e_wdata), .e_rdata(e_rdata), .e_err(e_err));

  idx_buffer_ram #(.DATA_W(64)) i_idx_buffer_ram_narrow (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_ready(n_hready), .h_rvalid(n_hrvalid), .h_rdata(n_hrdata),
    .e_start(n_start), .e_capture(e_capture), .e_index(e_index), .e_valid(n_valid),
    .e_ready(n_ready), .e_last(e_last), .e_wdata(e_wdata[63:0]), .e_rdata(n_rdata), .e_err(n_err));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); h_req = 1; h_we = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_req = 0; h_we = 0;
  endtask

  task automatic host_rd(input logic [15:0] a, output logic [31:0] d, output logic [31:0] nd, output logic v);
    @(negedge clk); h_req = 1; h_we = 0; h_addr = a;
    @(negedge clk); h_req = 0; d = h_rdata; nd = n_hrdata; v = h_rvalid;
  endtask

  task automatic expect_word(input logic [15:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d, nd; logic v;
    host_rd(a, d, nd, v);
    chk(v && d == exp, tag, {96'(v), d}, {96'(1), exp});
  endtask

  task automatic eng_start(input bit capm, input logic [12:0] idx);
    @(negedge clk); e_start = 1; e_capture = capm; e_index = idx;
    @(negedge clk); e_start = 0;
  endtask

  task automatic eng_beat(input logic [127:0] d, input bit last, output logic [127:0] rd);
    @(negedge clk); e_valid = 1; e_wdata = d; e_last = last;
    #1 rd = e_rdata;
    @(negedge clk); e_valid = 0; e_last = 0;
  endtask

  task automatic t_reset;
    chk(e_ready == 0 && e_err == 0 && h_rvalid == 0, "R1 control outputs after reset",
        {e_ready, e_err, h_rvalid}, 0);
    expect_word(16'hC000, 0, "R1 word 0 after reset");
    expect_word(16'hC010, 0, "R1 word 4 after reset");
    expect_word(16'hDFFC, 0, "R1 top word after reset");
  endtask

  task automatic t_host;
    host_wr(16'hC000, 32'h11111111); host_wr(16'hC004, 32'h22222222);
    host_wr(16'hC008, 32'h33333333); host_wr(16'hC00C, 32'h44444444);
    host_wr(16'hC010, 32'hABCD1234); host_wr(16'hC014, 32'hFAAB1234);
    host_wr(16'hC018, 32'h00000055); host_wr(16'hC01C, 32'h00000066);
    expect_word(16'hC010, 32'hABCD1234, "R2 host write/read");
    expect_word(16'hC004, 32'h22222222, "R2 host write/read odd word");
  endtask

  task automatic t_source;
    logic [127:0] rd;
    eng_start(0, 13'd1);
    chk(e_ready, "R11 ready after start", e_ready, 1);
    eng_beat('0, 0, rd);
    chk(rd == {32'hFAAB1234, 32'hABCD1234, 32'h44444444, 32'h33333333},
        "R3 outbound beat from entry 1", rd, {32'hFAAB1234, 32'hABCD1234, 32'h44444444, 32'h33333333});
    eng_beat('0, 1, rd);
    chk(rd == {32'h0, 32'h0, 32'h66, 32'h55}, "R6 outbound second beat", rd, {32'h0, 32'h0, 32'h66, 32'h55});
    chk(!e_ready, "R11 ready falls after last", e_ready, 0);
  endtask

  task automatic t_capture;
    logic [127:0] rd;
    eng_start(1, 13'h010);
    chk(!e_err, "R7 aligned index no error", e_err, 0);
    eng_beat({32'h88888888, 32'h44556677, 32'h00112233, 32'hAABBCCDD}, 0, rd);
    eng_beat({32'h88888888, 32'h44556677, 32'h55555555, 32'hFFEEDDCC}, 1, rd);
    expect_word(16'hC010, 32'hAABBCCDD, "R5 lane0 at aligned index");
    expect_word(16'hC014, 32'h00112233, "R5 lane1");
    expect_word(16'hC020, 32'hFFEEDDCC, "R6 second beat next slot");
    expect_word(16'hC02C, 32'h88888888, "R6 second beat top lane");
    expect_word(16'hC00C, 32'h44444444, "R9 word below slot kept");
    expect_word(16'hC030, 32'h00000000, "R9 word above slot kept");
  endtask

  task automatic t_misalign;
    logic [127:0] rd;
    eng_start(1, 13'h044);
    chk(e_err, "R7 misaligned index flags error", e_err, 1);
    eng_beat({32'hD4, 32'hD3, 32'hD2, 32'hD1}, 1, rd);
    chk(e_err, "R7 error held through transfer", e_err, 1);
    expect_word(16'hC040, 32'hD1, "R5 misaligned rounded down");
    expect_word(16'hC04C, 32'hD4, "R5 rounded beat top lane");
    expect_word(16'hC050, 32'h0, "R9 next slot untouched");
    eng_start(1, 13'h050);
    chk(!e_err, "R7 aligned start clears error", e_err, 0);
    eng_beat({32'h0, 32'h0, 32'h0, 32'h0}, 1, rd);
  endtask

  task automatic t_wrap;
    logic [127:0] rd;
    eng_start(1, 13'h1FF0);
    eng_beat({32'hE4, 32'hE3, 32'hE2, 32'hE1}, 0, rd);
    eng_beat({32'hF4, 32'hF3, 32'hF2, 32'hF1}, 1, rd);
    expect_word(16'hDFF0, 32'hE1, "R8 last slot of store");
    expect_word(16'hC000, 32'hF1, "R8 wrapped to word 0");
    expect_word(16'hC00C, 32'hF4, "R8 wrapped top lane");
  endtask

  task automatic t_priority;
    eng_start(1, 13'h100);
    @(negedge clk);
    e_valid = 1; e_last = 1; e_wdata = {32'hC4, 32'hC3, 32'hC2, 32'hC1};
    h_req = 1; h_we = 1; h_addr = 16'hC100; h_wdata = 32'h0BADF00D;
    #1 chk(!h_ready, "R10 host stalled during beat", h_ready, 0);
    @(negedge clk); e_valid = 0; e_last = 0;
    #1 chk(h_ready, "R10 host accepted after beat", h_ready, 1);
    @(negedge clk); h_req = 0; h_we = 0;
    expect_word(16'hC100, 32'h0BADF00D, "R10 stalled host write landed later");
    expect_word(16'hC104, 32'hC2, "R10 engine beat written");
  endtask

  task automatic t_narrow;
    logic [31:0] d, nd; logic v;
    @(negedge clk); n_start = 1; e_capture = 1; e_index = 13'd3;
    @(negedge clk); n_start = 0;
    chk(!n_err, "R7 narrow inbound never flags", n_err, 0);
    @(negedge clk); n_valid = 1; e_last = 1; e_wdata = {64'h0, 32'hBBBB0002, 32'hAAAA0001};
    @(negedge clk); n_valid = 0; e_last = 0;
    host_rd(16'hC018, d, nd, v);
    chk(nd == 32'hAAAA0001, "R4 narrow entry 3 low word", nd, 32'hAAAA0001);
    host_rd(16'hC01C, d, nd, v);
    chk(nd == 32'hBBBB0002, "R4 narrow entry 3 high word", nd, 32'hBBBB0002);
    host_rd(16'hC020, d, nd, v);
    chk(nd == 32'h0, "R9 narrow next entry kept", nd, 0);
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_host();
    t_source();
    t_capture();
    t_misalign();
    t_wrap();
    t_priority();
    t_narrow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule